// File: doc/BRIEF.md
# Load/Store Address Generator with Base Writeback

This block is one pipeline stage of a processor's memory path. For a single word or single byte load or store, it takes the decoded indexing controls, the base register value and either a 12-bit unsigned immediate or a shifted index register value. It produces the effective memory address and the updated base value. It also says whether that updated value must be written back to the base register, carries the transfer direction and size through, and names the base register to be written.

Two indexing styles are supported. In pre-indexed form the access uses the base adjusted by the offset, and the adjusted value is written back only on request. In post-indexed form the access uses the untouched base, and the adjusted value is always written back. The offset is added or subtracted according to a direction control. When the base register is the program counter, the base used is the address of the instruction plus eight. The stage registers its results one cycle after a valid input. The reset input is asynchronous and is released in step with the clock.

Top module: `ls_agen`

## Requirements
- R1: While reset is held and after it is released, before the first valid input, `out_valid` and `wb_en` are 0.
- R2: `out_valid` equals `in_valid` of the previous cycle. `wb_en` is 0 whenever `out_valid` is 0. `mem_addr`, `wb_val`, `wb_idx`, `out_load` and `out_byte` keep their values through a cycle with `in_valid` low.
- R3: When `off_is_reg` is 0, the offset is `imm_off` zero-extended (0 to 4095). `idx_val`, `sh_amt` and `sh_kind` have no effect.
- R4: When `off_is_reg` is 1, the offset is `idx_val` shifted by `sh_amt`. `sh_kind` selects the shift: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right. An amount of 0 passes `idx_val` unchanged.
- R5: `up_add`=1 adds the offset to the base and `up_add`=0 subtracts it, modulo 2^32.
- R6: With `pre_index`=1, `mem_addr` and `wb_val` both equal the base adjusted by the offset, and `wb_en` equals `wb_req`.
- R7: With `pre_index`=0, `mem_addr` equals the unmodified base, `wb_val` equals the base adjusted by the offset, and `wb_en` is 1 whatever `wb_req` is.
- R8: When `base_idx` is 15, the base is `instr_addr`+8 and `base_val` is ignored. This holds for both the address and the writeback value.
- R9: `out_load`, `out_byte` and `wb_idx` repeat `is_load`, `byte_acc` and `base_idx` of the accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input instruction fields are valid |
| instr_addr | input | 32 | Address of the instruction |
| base_idx | input | 4 | Base register number |
| base_val | input | 32 | Base register value |
| pre_index | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| up_add | input | 1 | 1 = add offset, 0 = subtract |
| byte_acc | input | 1 | 1 = byte access, 0 = word |
| wb_req | input | 1 | Writeback request for pre-indexed form |
| is_load | input | 1 | 1 = load, 0 = store |
| off_is_reg | input | 1 | 1 = shifted register offset, 0 = immediate |
| imm_off | input | 12 | Unsigned immediate offset |
| idx_val | input | 32 | Index register value |
| sh_amt | input | 5 | Shift amount for the index |
| sh_kind | input | 2 | Shift kind: 0 lsl, 1 lsr, 2 asr, 3 ror |
| out_valid | output | 1 | Outputs are valid |
| mem_addr | output | 32 | Effective memory address |
| out_load | output | 1 | Transfer direction |
| out_byte | output | 1 | Transfer size |
| wb_en | output | 1 | Base writeback enable |
| wb_idx | output | 4 | Register to write back |
| wb_val | output | 32 | New base value |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 12-bit immediate, 4-bit register numbers, register 15 as the program counter and a look-ahead of eight. With these values the largest immediate, 4095, and modulo-2^32 wraparound in both directions can be tested. All four shift kinds are reachable at 5-bit amounts, including rotation and sign fill at bit 31. The program counter substitution is exercised at index 15, in both pre-indexed and post-indexed form.

// File: rtl/ls_agen_pkg.sv
package ls_agen_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/ls_agen_rst_sync.sv
module ls_agen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/ls_agen_base.sv
module ls_agen_base #(
  parameter int DW       = 32,
  parameter int RW       = 4,
  parameter int PC_IDX   = 15,
  parameter int PC_AHEAD = 8
) (
  input  logic [DW-1:0] instr_addr,
  input  logic [RW-1:0] base_idx,
  input  logic [DW-1:0] base_val,
  output logic [DW-1:0] base_eff
);
  localparam logic [RW-1:0] PC_SEL  = RW'(PC_IDX);
  localparam logic [DW-1:0] PC_STEP = DW'(PC_AHEAD);

  always_comb begin
    if (base_idx == PC_SEL) base_eff = instr_addr + PC_STEP;
    else                    base_eff = base_val;
  end
endmodule

// File: rtl/ls_agen_offset.sv
module ls_agen_offset
  import ls_agen_pkg::*;
#(
  parameter int DW      = 32,
  parameter int OW      = 12,
  parameter int SW      = 5,
  parameter bit HAS_REG = 1'b1
) (
  input  logic          off_is_reg,
  input  logic [OW-1:0] imm_off,
  input  logic [DW-1:0] idx_val,
  input  logic [SW-1:0] sh_amt,
  input  logic [1:0]    sh_kind,
  output logic [DW-1:0] offset
);
  logic [DW-1:0] imm_ext;
  assign imm_ext = {{(DW-OW){1'b0}}, imm_off};

  generate
    if (HAS_REG) begin : g_reg
      localparam logic [SW:0] DW_L = (SW+1)'(DW);
      logic [DW-1:0] shifted;
      logic [SW:0]   back_amt;
      shift_kind_e   kind;

      assign kind     = shift_kind_e'(sh_kind);
      assign back_amt = DW_L - {1'b0, sh_amt};

      always_comb begin
        unique case (kind)
          SH_LSL:  shifted = idx_val << sh_amt;
          SH_LSR:  shifted = idx_val >> sh_amt;
          SH_ASR:  shifted = DW'($signed(idx_val) >>> sh_amt);
          default: shifted = (idx_val >> sh_amt) | (idx_val << back_amt);
        endcase
      end

      assign offset = off_is_reg ? shifted : imm_ext;
    end else begin : g_imm
      logic unused_ok;
      assign unused_ok = ^{off_is_reg, idx_val, sh_amt, sh_kind};
      assign offset    = imm_ext;
    end
  endgenerate
endmodule

// File: rtl/ls_agen_sum.sv
module ls_agen_sum #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base_eff,
  input  logic [DW-1:0] offset,
  input  logic          up_add,
  input  logic          pre_index,
  output logic [DW-1:0] addr_nx,
  output logic [DW-1:0] wbv_nx
);
  logic [DW-1:0] moved;

  always_comb begin
    if (up_add) moved = base_eff + offset;
    else        moved = base_eff - offset;
  end

  assign addr_nx = pre_index ? moved : base_eff;
  assign wbv_nx  = moved;
endmodule

// File: rtl/ls_agen.sv
module ls_agen
  import ls_agen_pkg::*;
#(
  parameter int DW       = 32,
  parameter int OW       = 12,
  parameter int RW       = 4,
  parameter int PC_IDX   = 15,
  parameter int PC_AHEAD = 8,
  parameter bit HAS_REG  = 1'b1,
  parameter int SW       = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] instr_addr,
  input  logic [RW-1:0] base_idx,
  input  logic [DW-1:0] base_val,
  input  logic          pre_index,
  input  logic          up_add,
  input  logic          byte_acc,
  input  logic          wb_req,
  input  logic          is_load,
  input  logic          off_is_reg,
  input  logic [OW-1:0] imm_off,
  input  logic [DW-1:0] idx_val,
  input  logic [SW-1:0] sh_amt,
  input  logic [1:0]    sh_kind,
  output logic          out_valid,
  output logic [DW-1:0] mem_addr,
  output logic          out_load,
  output logic          out_byte,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [DW-1:0] wb_val
);
  logic          rst_q;
  logic [DW-1:0] base_eff;
  logic [DW-1:0] offset;
  logic [DW-1:0] addr_nx, wbv_nx;

  ls_agen_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  ls_agen_base #(.DW(DW), .RW(RW), .PC_IDX(PC_IDX), .PC_AHEAD(PC_AHEAD)) u_base (
    .instr_addr(instr_addr), .base_idx(base_idx), .base_val(base_val),
    .base_eff(base_eff)
  );

  ls_agen_offset #(.DW(DW), .OW(OW), .SW(SW), .HAS_REG(HAS_REG)) u_off (
    .off_is_reg(off_is_reg), .imm_off(imm_off), .idx_val(idx_val),
    .sh_amt(sh_amt), .sh_kind(sh_kind), .offset(offset)
  );

  ls_agen_sum #(.DW(DW)) u_sum (
    .base_eff(base_eff), .offset(offset), .up_add(up_add),
    .pre_index(pre_index), .addr_nx(addr_nx), .wbv_nx(wbv_nx)
  );

  // next-state for control
  logic vld_d, wben_d;
  always_comb begin
    vld_d  = in_valid;
    wben_d = in_valid & (~pre_index | wb_req);
  end

  logic vld_q, wben_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q  <= 1'b0;
      wben_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      wben_q <= wben_d;
    end
  end

  // data registers with clock enable, no reset
  logic [DW-1:0] addr_q, wbv_q;
  logic [RW-1:0] idx_q;
  logic          load_q, byte_q;
  always_ff @(posedge clk) begin
    if (in_valid) begin
      addr_q <= addr_nx;
      wbv_q  <= wbv_nx;
      idx_q  <= base_idx;
      load_q <= is_load;
      byte_q <= byte_acc;
    end
  end

  assign out_valid = vld_q;
  assign wb_en     = wben_q;
  assign mem_addr  = addr_q;
  assign wb_val    = wbv_q;
  assign wb_idx    = idx_q;
  assign out_load  = load_q;
  assign out_byte  = byte_q;

  // assertions
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !out_valid |-> !wb_en);
  assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (!in_valid && out_valid) |=> $stable(mem_addr) && $stable(wb_val));
  assert_pre_same_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && pre_index) |=> (mem_addr == wb_val));
  assert_pre_nowb_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && pre_index && !wb_req) |=> !wb_en);
  assert_post_wb_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !pre_index) |=> wb_en);
  assert_post_base_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !pre_index) |=> (mem_addr == $past(base_eff)));
  assert_mirror_R9: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> (out_load == $past(is_load)) && (out_byte == $past(byte_acc))
                 && (wb_idx == $past(base_idx)));
endmodule

// File: tb/sim_ls_agen.sv
`timescale 1ns/1ps
module sim_ls_agen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr_addr;
  logic [3:0]  base_idx;
  logic [31:0] base_val;
  logic        pre_index, up_add, byte_acc, wb_req, is_load, off_is_reg;
  logic [11:0] imm_off;
  logic [31:0] idx_val;
  logic [4:0]  sh_amt;
  logic [1:0]  sh_kind;
  logic        out_valid, out_load, out_byte, wb_en;
  logic [31:0] mem_addr, wb_val;
  logic [3:0]  wb_idx;

  always #2 clk = ~clk;

  ls_agen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr_addr(instr_addr),
    .base_idx(base_idx), .base_val(base_val), .pre_index(pre_index),
    .up_add(up_add), .byte_acc(byte_acc), .wb_req(wb_req), .is_load(is_load),
    .off_is_reg(off_is_reg), .imm_off(imm_off), .idx_val(idx_val),
    .sh_amt(sh_amt), .sh_kind(sh_kind), .out_valid(out_valid),
    .mem_addr(mem_addr), .out_load(out_load), .out_byte(out_byte),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        pre, up, wb, isreg, ld, byt;
    logic [31:0] base;
    logic [11:0] imm;
    logic [31:0] idx;
    logic [4:0]  amt;
    logic [1:0]  kind;
    logic [31:0] ea, ewv;
    logic        ewb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    // imm ignores idx (R3), P/U/W sweep (R5 R6 R7)
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'h1000,12'h019,32'hFFFF_FFFF,5'd3,2'd0,32'h1019,32'h1019,1'b0},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,32'h1000,12'h019,32'h0,5'd0,2'd0,32'h1019,32'h1019,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,32'h1000,12'h019,32'h0,5'd0,2'd0,32'h0FE7,32'h0FE7,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,32'h1000,12'hFFF,32'h0,5'd0,2'd0,32'h0001,32'h0001,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h1000,12'hFFF,32'h0,5'd0,2'd0,32'h1000,32'h1FFF,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,32'h1000,12'h004,32'h0,5'd0,2'd0,32'h1000,32'h1004,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h1000,12'h010,32'h0,5'd0,2'd0,32'h1000,32'h0FF0,1'b1},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h1000,12'h010,32'h0,5'd0,2'd0,32'h1000,32'h0FF0,1'b1},
    // register offsets (R4)
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,32'h1000,12'hABC,32'h6,5'd2,2'd0,32'h1018,32'h1018,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h1000,12'h000,32'h100,5'd4,2'd1,32'h0FF0,32'h0FF0,1'b0},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,32'h1000,12'h000,32'h8000_0000,5'd4,2'd2,32'hF800_1000,32'hF800_1000,1'b0},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,32'h0,12'h000,32'hAB,5'd8,2'd3,32'h0,32'hAB00_0000,1'b1},
    // wraparound (R5)
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'hFFFF_FFF0,12'h020,32'h0,5'd0,2'd0,32'h10,32'h10,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,32'h4,12'h008,32'h0,5'd0,2'd0,32'hFFFF_FFFC,32'hFFFF_FFFC,1'b0},
    // shift amount zero passes index (R4)
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,32'h0,12'h000,32'h1234,5'd0,2'd1,32'h1234,32'h1234,1'b0}
  };

  task automatic drive(input vec_t v, input logic [3:0] bidx, input logic [31:0] ia);
    @(negedge clk);
    in_valid = 1'b1; pre_index = v.pre; up_add = v.up; wb_req = v.wb;
    off_is_reg = v.isreg; is_load = v.ld; byte_acc = v.byt;
    base_val = v.base; imm_off = v.imm; idx_val = v.idx;
    sh_amt = v.amt; sh_kind = v.kind; base_idx = bidx; instr_addr = ia;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr_addr = '0; base_idx = '0; base_val = '0;
    pre_index = 1'b0; up_add = 1'b0; byte_acc = 1'b0; wb_req = 1'b0; is_load = 1'b0;
    off_is_reg = 1'b0; imm_off = '0; idx_val = '0; sh_amt = '0; sh_kind = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {31'b0, out_valid}, 32'd0);
    chk("R1 wb_en in reset", {31'b0, wb_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
    chk("R1 wb_en after reset", {31'b0, wb_en}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i], 4'd5, 32'h0000_8000);
      chk($sformatf("R2 out_valid vec%0d", i), {31'b0, out_valid}, 32'd1);
      chk($sformatf("R6/R7 mem_addr vec%0d", i), mem_addr, VT[i].ea);
      chk($sformatf("R5 wb_val vec%0d", i), wb_val, VT[i].ewv);
      chk($sformatf("R6/R7 wb_en vec%0d", i), {31'b0, wb_en}, {31'b0, VT[i].ewb});
      chk($sformatf("R9 out_load vec%0d", i), {31'b0, out_load}, {31'b0, VT[i].ld});
      chk($sformatf("R9 out_byte vec%0d", i), {31'b0, out_byte}, {31'b0, VT[i].byt});
      chk($sformatf("R9 wb_idx vec%0d", i), {28'b0, wb_idx}, 32'd5);
    end

    // R2 idle cycle: valid drops, wb_en low, data held
    @(negedge clk);
    chk("R2 idle out_valid", {31'b0, out_valid}, 32'd0);
    chk("R2 idle wb_en", {31'b0, wb_en}, 32'd0);
    chk("R2 idle mem_addr held", mem_addr, 32'h1234);
    chk("R2 idle wb_val held", wb_val, 32'h1234);

    // R8 base index 15, pre-indexed add
    drive('{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,32'hDEAD_BEEF,12'h004,32'h0,5'd0,2'd0,32'h0,32'h0,1'b0},
          4'd15, 32'h0000_2000);
    chk("R8 pc base pre mem_addr", mem_addr, 32'h0000_200C);
    chk("R8 pc base pre wb_val", wb_val, 32'h0000_200C);
    chk("R9 wb_idx pc", {28'b0, wb_idx}, 32'd15);

    // R8 base index 15, post-indexed subtract
    drive('{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h1111_1111,12'h004,32'h0,5'd0,2'd0,32'h0,32'h0,1'b0},
          4'd15, 32'h0000_2000);
    chk("R8 pc base post mem_addr", mem_addr, 32'h0000_2008);
    chk("R8 pc base post wb_val", wb_val, 32'h0000_2004);
    chk("R7 pc base post wb_en", {31'b0, wb_en}, 32'd1);

    // R3 immediate ignores shift controls with a large index
    drive('{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h100,12'h001,32'h7FFF_FFFF,5'd31,2'd3,32'h0,32'h0,1'b0},
          4'd2, 32'h0);
    chk("R3 imm ignores idx mem_addr", mem_addr, 32'h101);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule